// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block is the integer multiply and divide engine that sits beside the integer pipeline of a load/store processor. It keeps two result words, an upper one (Hi) and a lower one (Lo). It accepts six commands: signed multiply, unsigned multiply, signed divide, unsigned divide, read Hi and read Lo. A multiply leaves the double-width product across Hi:Lo. A divide leaves the quotient in Lo and the remainder in Hi.

The arithmetic is iterative. One double-width shift register, which is Hi:Lo itself, and one adder one bit wider than a word carry out a shift-and-add multiply or a restoring shift-and-subtract divide, one bit per clock. Signed operations first reduce both operands to magnitudes and run the unsigned loop. A single fix-up cycle then restores the signs. During a run, `busy` is high, and any command presented to the unit is not taken. A read request stalls until `busy` falls. The processor holds the request until `rd_valid` answers it.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, `busy` is low, and reading Hi (op 3'd5) and Lo (op 3'd6) both return zero.
- R2: Unsigned multiply (op 3'd2) treats both operands as unsigned. It leaves the upper half of the 64-bit product in Hi and the lower half in Lo.
- R3: Signed multiply (op 3'd1) treats both operands as two's complement. It leaves the full 64-bit two's-complement product across Hi:Lo. This includes the most-negative by most-negative case.
- R4: Unsigned divide (op 3'd4) with a non-zero divisor leaves floor(a/b) in Lo and a mod b in Hi.
- R5: Signed divide (op 3'd3) with a non-zero divisor rounds the quotient toward zero and gives the remainder the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF gives Lo = 0x80000000 and Hi = 0.
- R6: Dividing by zero, signed or unsigned, raises nothing. It leaves Lo = 0xFFFFFFFF and Hi equal to the dividend.
- R7: When the unit is not busy, a read command presents Hi (op 3'd5) or Lo (op 3'd6) on `rd_data` with `rd_valid` high in the same cycle. A read changes neither word. Op 3'd0 and 3'd7 are no-ops.
- R8: `busy` rises on the clock edge that takes an arithmetic command. It stays high for exactly WIDTH+1 cycles (33 by default), and the result is readable in the first cycle it is low.
- R9: A read presented while `busy` is high keeps `rd_valid` low. It completes in the first cycle `busy` is low and returns the finished result.
- R10: An arithmetic command presented while `busy` is high is ignored. The running result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Command: 0 none, 1 signed mul, 2 unsigned mul, 3 signed div, 4 unsigned div, 5 read Hi, 6 read Lo, 7 none |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| rd_data | output | 32 | Hi or Lo contents for a read command, zero otherwise |
| rd_valid | output | 1 | A read command is answered this cycle |
| busy | output | 1 | An arithmetic command is in progress |

## Verification
The bench aims at the sign corners. These are the most-negative operand in both multiply and divide, the overflowing signed quotient, and every sign pairing in signed divide. A unit that negated the wrong word, or used a 32-bit negate on the product, would return a wrong Hi. Divide by zero is run with both signs of dividend, because a sign fix-up applied blindly would turn the all-ones quotient into one. Reads are issued while a run is in progress, and a second command is presented mid-run. A unit that answered early would hand back stale Hi/Lo, and one that accepted the command would corrupt the result.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MULS = 3'd1,
    OP_MULU = 3'd2,
    OP_DIVS = 3'd3,
    OP_DIVU = 3'd4,
    OP_RDHI = 3'd5,
    OP_RDLO = 3'd6,
    OP_RSVD = 3'd7
  } hilo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } hilo_state_e;

endpackage

// File: rtl/hilo_sign_prep.sv
// Reduces operands to magnitudes and decides which result words need negating.
module hilo_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  input  logic         is_div,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         neg_main,
  output logic         neg_rem
);
  logic a_neg, b_neg, b_zero;

  assign a_neg  = is_signed & a[W-1];
  assign b_neg  = is_signed & b[W-1];
  assign b_zero = (b == '0);

  assign a_mag = a_neg ? -a : a;
  assign b_mag = b_neg ? -b : b;

  // product/quotient sign; a zero divisor keeps the all-ones quotient as is
  assign neg_main = is_div ? ((a_neg ^ b_neg) & ~b_zero) : (a_neg ^ b_neg);
  // remainder follows the dividend (also yields Hi = dividend on divide by zero)
  assign neg_rem  = is_div & a_neg;
endmodule

// File: rtl/hilo_iter_step.sv
// One bit of shift-add multiply or restoring divide on the shared Hi:Lo register.
module hilo_iter_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   opnd,
  input  logic           is_div,
  output logic [2*W-1:0] acc_nxt
);
  localparam int W2 = 2 * W;

  logic [W:0]    mul_sum;
  logic [W2:0]   mul_cat;
  logic [W2-1:0] mul_nxt;
  logic [W:0]    div_top;
  logic [W:0]    div_diff;
  logic [W-1:0]  div_low;
  logic [W2-1:0] div_nxt;

  // multiply: conditionally add multiplicand to Hi, then shift Hi:Lo right
  always_comb begin
    mul_sum = {1'b0, acc[W2-1:W]} + (acc[0] ? {1'b0, opnd} : {(W+1){1'b0}});
    mul_cat = {mul_sum, acc[W-1:0]};
    mul_nxt = mul_cat[W2:1];
  end

  // divide: shift Hi:Lo left, trial-subtract divisor from Hi, keep if non-negative
  always_comb begin
    div_top  = acc[W2-1:W-1];
    div_low  = {acc[W-2:0], 1'b0};
    div_diff = div_top - {1'b0, opnd};
    if (div_diff[W]) div_nxt = {div_top[W-1:0], div_low};
    else             div_nxt = {div_diff[W-1:0], div_low[W-1:1], 1'b1};
  end

  assign acc_nxt = is_div ? div_nxt : mul_nxt;
endmodule

// File: rtl/hilo_seq_ctrl.sv
// Sequencer: idle -> WIDTH iteration cycles -> one sign fix-up cycle -> idle.
module hilo_seq_ctrl
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic in_run,
  output logic in_fix,
  output logic busy
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  hilo_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign in_run = (state_q == ST_RUN);
  assign in_fix = (state_q == ST_FIX);
  assign busy   = (state_q != ST_IDLE);
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             busy
);
  localparam int W2 = 2 * WIDTH;

  hilo_op_e op_e;
  logic is_arith, is_div_op, is_signed_op, start;
  logic in_run, in_fix;

  logic [W2-1:0]    acc_q, acc_d, step_out;
  logic [WIDTH-1:0] opnd_q;
  logic             div_q, neg_main_q, neg_rem_q;
  logic             acc_en;
  logic [WIDTH-1:0] hi_q, lo_q;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic             neg_main, neg_rem;

  assign op_e         = hilo_op_e'(op);
  assign is_arith     = (op_e == OP_MULS) || (op_e == OP_MULU) ||
                        (op_e == OP_DIVS) || (op_e == OP_DIVU);
  assign is_div_op    = (op_e == OP_DIVS) || (op_e == OP_DIVU);
  assign is_signed_op = (op_e == OP_MULS) || (op_e == OP_DIVS);
  assign start        = is_arith && !busy;

  hilo_seq_ctrl #(.W(WIDTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .in_run (in_run),
    .in_fix (in_fix),
    .busy   (busy)
  );

  hilo_sign_prep #(.W(WIDTH)) u_prep (
    .a         (opa),
    .b         (opb),
    .is_signed (is_signed_op),
    .is_div    (is_div_op),
    .a_mag     (a_mag),
    .b_mag     (b_mag),
    .neg_main  (neg_main),
    .neg_rem   (neg_rem)
  );

  hilo_iter_step #(.W(WIDTH)) u_step (
    .acc     (acc_q),
    .opnd    (opnd_q),
    .is_div  (div_q),
    .acc_nxt (step_out)
  );

  // Hi:Lo next value
  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (start) begin
      acc_en = 1'b1;
      if (is_div_op) acc_d = {{WIDTH{1'b0}}, a_mag};
      else           acc_d = {{WIDTH{1'b0}}, b_mag};
    end else if (in_run) begin
      acc_en = 1'b1;
      acc_d  = step_out;
    end else if (in_fix) begin
      acc_en = 1'b1;
      if (div_q) begin
        acc_d[W2-1:WIDTH] = neg_rem_q  ? -acc_q[W2-1:WIDTH] : acc_q[W2-1:WIDTH];
        acc_d[WIDTH-1:0]  = neg_main_q ? -acc_q[WIDTH-1:0]  : acc_q[WIDTH-1:0];
      end else begin
        acc_d = neg_main_q ? -acc_q : acc_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // per-command context captured when a command is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q     <= '0;
      div_q      <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (start) begin
      opnd_q     <= is_div_op ? b_mag : a_mag;
      div_q      <= is_div_op;
      neg_main_q <= neg_main;
      neg_rem_q  <= neg_rem;
    end
  end

  assign hi_q = acc_q[W2-1:WIDTH];
  assign lo_q = acc_q[WIDTH-1:0];

  // read path
  always_comb begin
    rd_valid = 1'b0;
    rd_data  = '0;
    if (!busy) begin
      if (op_e == OP_RDHI) begin
        rd_valid = 1'b1;
        rd_data  = hi_q;
      end else if (op_e == OP_RDLO) begin
        rd_valid = 1'b1;
        rd_data  = lo_q;
      end
    end
  end
endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic             busy,
  input logic             rd_valid,
  input logic [WIDTH-1:0] hi_q,
  input logic [WIDTH-1:0] lo_q
);
  logic arith_req;
  logic [15:0] busy_cnt;

  assign arith_req = (op >= 3'd1) && (op <= 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R8: a command taken while idle raises busy on the next cycle
  a_r8_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && arith_req) |=> busy);

  // R8: busy lasts exactly WIDTH+1 cycles
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 16'(WIDTH + 1)));

  // R9: no read answered during a run
  a_r9_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);

  // R7: idle cycles without an arithmetic command leave Hi and Lo untouched
  a_r7_idle_keeps_hilo: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !arith_req) |=> ($stable(hi_q) && $stable(lo_q)));

  // R10: while running, busy cannot drop early because of a new command
  a_r10_busy_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arith_req && (busy_cnt < 16'(WIDTH))) |=> busy);
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op),
  .busy     (busy),
  .rd_valid (rd_valid),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/hilo_muldiv_unit_bench.sv
module hilo_muldiv_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [2:0]   op;
  logic [W-1:0] opa, opb;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic         busy;

  int n_checks;
  int n_fails;
  bit finished;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  hilo_muldiv_unit #(.WIDTH(W)) u_hilo_muldiv_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the unit answers reads
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fails++;
        $display("FAIL R9 unexpected read answer actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // reference model from the requirements
  task automatic model(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] hi, output logic [W-1:0] lo);
    logic [63:0] p;
    longint sa, sb;
    int q, r;
    case (c)
      3'd1: begin
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p  = 64'(sa * sb);
        hi = p[63:32]; lo = p[31:0];
      end
      3'd2: begin
        p  = {32'b0, a} * {32'b0, b};
        hi = p[63:32]; lo = p[31:0];
      end
      3'd3: begin
        if (b == 0) begin lo = '1; hi = a; end
        else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin lo = a; hi = '0; end
        else begin
          q = $signed(a) / $signed(b);
          r = $signed(a) % $signed(b);
          lo = q; hi = r;
        end
      end
      default: begin
        if (b == 0) begin lo = '1; hi = a; end
        else begin lo = a / b; hi = a % b; end
      end
    endcase
  endtask

  // drive one command for one cycle; optionally wait for completion
  task automatic issue(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit wait_done, output int busy_cycles);
    op = c; opa = a; opb = b;
    @(posedge clk); #1;
    op = 3'd0;
    busy_cycles = 0;
    if (wait_done) begin
      while (busy) begin
        busy_cycles++;
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic read_word(input logic [2:0] c, input logic [W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    op = c;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    op = 3'd0;
  endtask

  task automatic run_vec(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag);
    logic [W-1:0] eh, el;
    int bc;
    model(c, a, b, eh, el);
    issue(c, a, b, 1'b1, bc);
    read_word(3'd5, eh, {tag, " Hi"});
    read_word(3'd6, el, {tag, " Lo"});
  endtask

  initial begin
    logic [W-1:0] eh, el, x, y;
    logic [31:0] seed;
    int bc;
    op = 3'd0; opa = '0; opb = '0;
    n_checks = 0; n_fails = 0; finished = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 busy after reset", {31'b0, busy}, 32'd0);
    read_word(3'd5, 32'd0, "R1 Hi after reset");
    read_word(3'd6, 32'd0, "R1 Lo after reset");

    // R2 unsigned multiply
    run_vec(3'd2, 32'd7, 32'd3, "R2 7*3");
    run_vec(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max*max");
    run_vec(3'd2, 32'h8000_0000, 32'd2, "R2 carry into Hi");

    // R3 signed multiply
    run_vec(3'd1, -32'sd5, 32'd7, "R3 -5*7");
    run_vec(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 -1*-1");
    run_vec(3'd1, 32'h8000_0000, 32'h8000_0000, "R3 min*min");
    run_vec(3'd1, 32'h8000_0000, 32'd1, "R3 min*1");

    // R4 unsigned divide
    run_vec(3'd4, 32'd7, 32'd2, "R4 7/2");
    run_vec(3'd4, 32'hFFFF_FFFF, 32'd1, "R4 max/1");
    run_vec(3'd4, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4 below divisor");

    // R5 signed divide, all sign pairings and overflow
    run_vec(3'd3, -32'sd7, 32'd2, "R5 -7/2");
    run_vec(3'd3, 32'd7, -32'sd2, "R5 7/-2");
    run_vec(3'd3, -32'sd7, -32'sd2, "R5 -7/-2");
    run_vec(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min/-1");

    // R6 divide by zero
    run_vec(3'd4, 32'd5, 32'd0, "R6 unsigned 5/0");
    run_vec(3'd3, -32'sd9, 32'd0, "R6 signed -9/0");
    run_vec(3'd3, 32'h8000_0000, 32'd0, "R6 signed min/0");

    // R7 repeated reads do not disturb Hi/Lo; no-op codes have no effect
    model(3'd3, 32'h8000_0000, 32'd0, eh, el);
    op = 3'd7; @(posedge clk); #1; op = 3'd0;
    read_word(3'd6, el, "R7 Lo reread");
    read_word(3'd5, eh, "R7 Hi reread");
    read_word(3'd5, eh, "R7 Hi reread twice");

    // R8 busy length
    issue(3'd2, 32'd11, 32'd13, 1'b1, bc);
    check("R8 busy cycles", 32'(bc), 32'd33);
    read_word(3'd6, 32'd143, "R8 Lo after busy falls");

    // R9 read during a run stalls and returns the new result
    model(3'd4, 32'd1000, 32'd7, eh, el);
    issue(3'd4, 32'd1000, 32'd7, 1'b0, bc);
    read_word(3'd6, el, "R9 stalled Lo");
    read_word(3'd5, eh, "R9 Hi after stall");

    // R10 command while busy is ignored
    model(3'd2, 32'h1234_5678, 32'h9ABC_DEF0, eh, el);
    issue(3'd2, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, bc);
    op = 3'd3; opa = 32'd77; opb = 32'd5;
    repeat (5) @(posedge clk);
    #1 op = 3'd0;
    read_word(3'd5, eh, "R10 Hi unaffected");
    read_word(3'd6, el, "R10 Lo unaffected");
    check("R10 idle after run", {31'b0, busy}, 32'd0);

    // pseudo-random sweep across all four arithmetic commands
    seed = 32'hACE1_2357;
    for (int i = 0; i < 24; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      x = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      y = (i % 3 == 0) ? (seed >> (i % 29)) : seed;
      case (i % 4)
        0: run_vec(3'd2, x, y, "R2 sweep");
        1: run_vec(3'd1, x, y, "R3 sweep");
        2: run_vec(3'd4, x, y, "R4 sweep");
        default: run_vec(3'd3, x, y, "R5 sweep");
      endcase
    end

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R9 unanswered reads actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule